// File: doc/BRIEF.md
# Nibble-Loaded Address Register

This block holds the fetched instruction byte and builds a 12-bit memory address from it, four bits at a time. Each held byte is read as three fields: a 3-bit opcode in the top bits, a one-bit section flag below it, and a 4-bit operand nibble at the bottom. The opcode and the flag go straight out to the rest of the control path. The nibble is the only source of new address bits.

Two opcodes write the address register. Opcode 000 writes the least significant nibble. Opcode 001 writes either the middle or the top nibble, and the flag picks which one. A program that stays within a 16-word neighbourhood therefore changes its target with one instruction. A far jump costs up to three instructions. The sequencer strobes `fetch_en` to capture a byte and `load_en` to carry out the address write.

Top module: `nibble_addr_reg`

## Requirements
- R1: On a rising edge with `fetch_en` high, the byte on `instr_in` is captured. After that edge, `op_out` equals captured bits [7:5] and `sel_out` equals captured bit 4.
- R2: While `fetch_en` is low, `op_out` and `sel_out` keep their values, whatever `instr_in` does.
- R3: On an edge with `load_en` high and held opcode 000, `addr_out[3:0]` takes the held bits [3:0]. `addr_out[11:4]` stays unchanged.
- R4: On an edge with `load_en` high, held opcode 001 and held bit 4 at 0, `addr_out[7:4]` takes the held bits [3:0]. All other address bits stay unchanged.
- R5: On an edge with `load_en` high, held opcode 001 and held bit 4 at 1, `addr_out[11:8]` takes the held bits [3:0]. All other address bits stay unchanged.
- R6: With `load_en` high and any held opcode from 010 to 111, `addr_out` does not change, whatever the flag is.
- R7: With `load_en` low, `addr_out` does not change.
- R8: Reset is synchronous and active high. An edge with `rst` high clears `addr_out`, `op_out` and `sel_out` to zero.
- R9: When `fetch_en` and `load_en` are both high on the same edge, the address write uses the previously held byte. The new byte only sets the decode outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Capture strobe for the instruction byte |
| load_en | input | 1 | Address write strobe from the sequencer |
| instr_in | input | 8 | Instruction byte from memory |
| addr_out | output | 12 | Assembled address |
| op_out | output | 3 | Opcode field of the held byte |
| sel_out | output | 1 | Section flag of the held byte |

## Verification
The hardest case to reach is the edge where a fetch and an address write coincide. On that edge the old held byte and the new one both matter, and their fields differ. The stimulus first holds a low-nibble write byte. It then raises both strobes on one edge together with a top-section byte. One check confirms that only the low nibble changed. A second write, without a fetch, then confirms that the new byte reaches the top section. Each section write is also run while the other sections hold distinct non-zero values, so a write that leaks into a neighbouring section shows at the port.

// File: rtl/nibble_addr_reg.sv
module nibble_addr_reg #(
  parameter int NIB_W = 4,
  parameter int OP_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fetch_en,
  input  logic                      load_en,
  input  logic [NIB_W+OP_W:0]       instr_in,
  output logic [3*NIB_W-1:0]        addr_out,
  output logic [OP_W-1:0]           op_out,
  output logic                      sel_out
);
  localparam int INSTR_W = NIB_W + OP_W + 1;
  localparam int SECS    = 3;
  localparam int ADDR_W  = SECS * NIB_W;
  localparam logic [OP_W-1:0] OP_LOW  = '0;
  localparam logic [OP_W-1:0] OP_SECT = OP_W'(1);

  logic [INSTR_W-1:0] ir_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [NIB_W-1:0]   nib;
  logic [SECS-1:0]    sec_we;

  always_ff @(posedge clk) begin
    if (rst)           ir_q <= '0;
    else if (fetch_en) ir_q <= instr_in;
  end

  assign nib     = ir_q[NIB_W-1:0];
  assign sel_out = ir_q[NIB_W];
  assign op_out  = ir_q[INSTR_W-1 -: OP_W];

  genvar k;
  generate
    for (k = 0; k < SECS; k++) begin : g_sec
      if (k == 0) begin : g_low
        assign sec_we[k] = load_en && (op_out == OP_LOW);
      end else begin : g_up
        localparam logic SEL_VAL = 1'(k - 1);
        assign sec_we[k] = load_en && (op_out == OP_SECT) && (sel_out == SEL_VAL);
      end

      always_ff @(posedge clk) begin
        if (rst)            addr_q[k*NIB_W +: NIB_W] <= '0;
        else if (sec_we[k]) addr_q[k*NIB_W +: NIB_W] <= nib;
      end
    end
  endgenerate

  assign addr_out = addr_q;
endmodule

module nibble_addr_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        fetch_en,
  input logic        load_en,
  input logic [7:0]  instr_in,
  input logic [7:0]  held,
  input logic [11:0] addr_out,
  input logic [2:0]  op_out,
  input logic        sel_out
);
  p_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> (op_out == $past(instr_in[7:5]) && sel_out == $past(instr_in[4])));

  p_hold_ir_r2: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> ($stable(op_out) && $stable(sel_out)));

  p_low_r3: assert property (@(posedge clk) disable iff (rst)
    (load_en && op_out == 3'b000) |=>
      (addr_out[3:0] == $past(held[3:0]) && addr_out[11:4] == $past(addr_out[11:4])));

  p_mid_r4: assert property (@(posedge clk) disable iff (rst)
    (load_en && op_out == 3'b001 && !sel_out) |=>
      (addr_out[7:4] == $past(held[3:0]) && addr_out[11:8] == $past(addr_out[11:8])
       && addr_out[3:0] == $past(addr_out[3:0])));

  p_high_r5: assert property (@(posedge clk) disable iff (rst)
    (load_en && op_out == 3'b001 && sel_out) |=>
      (addr_out[11:8] == $past(held[3:0]) && addr_out[7:0] == $past(addr_out[7:0])));

  p_other_r6: assert property (@(posedge clk) disable iff (rst)
    (load_en && op_out[2:1] != 2'b00) |=> $stable(addr_out));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(addr_out));

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (addr_out == 12'h000 && op_out == 3'b000 && !sel_out));
endmodule

bind nibble_addr_reg nibble_addr_reg_chk u_chk (
  .clk(clk), .rst(rst), .fetch_en(fetch_en), .load_en(load_en),
  .instr_in(instr_in), .held(ir_q), .addr_out(addr_out),
  .op_out(op_out), .sel_out(sel_out)
);

// File: tb/nibble_addr_reg_test.sv
module nibble_addr_reg_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        fetch_en = 0;
  logic        load_en = 0;
  logic [7:0]  instr_in = 8'h00;
  logic [11:0] addr_out;
  logic [2:0]  op_out;
  logic        sel_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nibble_addr_reg uut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .load_en(load_en),
    .instr_in(instr_in), .addr_out(addr_out), .op_out(op_out), .sel_out(sel_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fe, input logic le, input logic [7:0] b);
    @(negedge clk);
    fetch_en = fe; load_en = le; instr_in = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1; fetch_en = 0; load_en = 0;
    @(posedge clk); #1;
    check("R8 addr", addr_out, 12'h000);
    check("R8 op", op_out, 0);
    check("R8 sel", sel_out, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_decode();
    cyc(1, 0, 8'hA7);
    check("R1 op", op_out, 3'd5);
    check("R1 sel", sel_out, 0);
    cyc(1, 0, 8'h3C);
    check("R1 op", op_out, 3'd1);
    check("R1 sel", sel_out, 1);
  endtask

  task automatic t_ir_hold();
    cyc(1, 0, 8'h25);
    cyc(0, 0, 8'hFF);
    cyc(0, 0, 8'hD0);
    check("R2 op", op_out, 3'd1);
    check("R2 sel", sel_out, 0);
  endtask

  task automatic t_sections();
    cyc(1, 0, 8'h23); cyc(0, 1, 8'h00);
    check("R4 mid", addr_out, 12'h030);
    cyc(1, 0, 8'h3E); cyc(0, 1, 8'h00);
    check("R5 high", addr_out, 12'hE30);
    cyc(1, 0, 8'h05); cyc(0, 1, 8'h00);
    check("R3 low", addr_out, 12'hE35);
    cyc(1, 0, 8'h0F); cyc(0, 1, 8'h00);
    check("R3 low again", addr_out, 12'hE3F);
    cyc(1, 0, 8'h29); cyc(0, 1, 8'h00);
    check("R4 mid over", addr_out, 12'hE9F);
    cyc(1, 0, 8'h31); cyc(0, 1, 8'h00);
    check("R5 high over", addr_out, 12'h19F);
  endtask

  task automatic t_other_ops();
    for (int op = 2; op < 8; op++) begin
      for (int s = 0; s < 2; s++) begin
        cyc(1, 0, {op[2:0], s[0], 4'h6});
        cyc(0, 1, 8'h00);
        check("R6 other opcode", addr_out, 12'h19F);
      end
    end
  endtask

  task automatic t_no_load();
    cyc(1, 0, 8'h0A);
    cyc(0, 0, 8'h00);
    cyc(0, 0, 8'h00);
    check("R7 no load low", addr_out, 12'h19F);
    cyc(1, 0, 8'h3C);
    cyc(0, 0, 8'h00);
    check("R7 no load high", addr_out, 12'h19F);
  endtask

  task automatic t_same_edge();
    cyc(1, 0, 8'h09);
    cyc(1, 1, 8'h37);
    check("R9 old byte used", addr_out, 12'h199);
    check("R9 new op", op_out, 3'd1);
    check("R9 new sel", sel_out, 1);
    cyc(0, 1, 8'h00);
    check("R9 new byte next", addr_out, 12'h799);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_decode();
    t_ir_hold();
    t_sections();
    t_other_ops();
    t_no_load();
    t_same_edge();
    t_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule